// File: doc/BRIEF.md
# Set-Associative Data Address Translator

This block turns a data virtual address into a physical address using a set-associative table of page entries. Each entry is a pair of 32-bit words: a match word (tag, valid bit, use-recency counter) and a translate word (physical page number, cache-inhibit bit, four access-permission bits). The set is picked by the low bits of the virtual page number. The ways of that set are compared against the upper address bits. On a hit the page number from the translate word is joined with the page offset, and the permissions are checked against the access direction and the privilege level.

A request is presented with a one-cycle `req_valid` strobe. The result (physical address, cache-inhibit, hit, page fault, miss, faulting address) appears registered on the following cycle together with `rsp_valid`. Software loads entries through a register-style write port and can read back any match word. When translation is switched off or the unit is absent, the address passes through unchanged. A probe mode performs a lookup that has no side effects.

Top module: `dtlb_xlate`

## Requirements
- R1: When `mmu_en` and `mmu_present` are not both 1, a request returns `paddr` equal to `vaddr`, `cache_inh` equal to `vaddr[31]`, and hit, page fault and miss all 0.
- R2: The set is `vaddr[PAGE_LOG2 +: SET_LOG2]`. A way hits only if match-word bit 0 (valid) is 1 and match-word bits [31:PAGE_LOG2+SET_LOG2] equal the same bits of `vaddr`.
- R3: On a hit, `paddr` is translate-word bits [31:PAGE_LOG2] joined with `vaddr[PAGE_LOG2-1:0]`, and `cache_inh` is translate-word bit 1.
- R4: Permission bits in the translate word are bit 6 supervisor read, bit 7 supervisor write, bit 8 user read and bit 9 user write. A non-probe hit that lacks the permission for its mode and direction returns `hit`=1, `page_fault`=1 and `fault_addr`=`vaddr`.
- R5: A non-probe lookup with no hitting way returns `tlb_miss`=1, `paddr`=0, `hit`=0 and `fault_addr`=`vaddr`.
- R6: The recency counter is match-word bits [6 +: USE_W]. On a non-probe hit, every way of the set whose counter is nonzero is decremented by one, and the hit way's counter is then ORed with (sets−1) truncated to USE_W bits.
- R7: A probe lookup leaves all counters unchanged and never raises `page_fault` or `tlb_miss`. On a miss or a permission failure it returns `paddr`=0 and `hit`=0.
- R8: Results are registered. `rsp_valid` is 1 exactly in the cycle after an accepted request.
- R9: A write has priority: a request in a cycle with `wr_en`=1 gets no response. `wr_sel`=0 writes the match word and 1 writes the translate word of (`wr_way`, `wr_set`). A written match word reads back on `rd_match`.
- R10: `cfg_word` holds (ways−1) in bits [1:0] and log2(sets) in bits [6:3], with all other bits 0.
- R11: After reset every entry is invalid, `rsp_valid` is 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| vaddr | input | 32 | Virtual address |
| is_write | input | 1 | 1 for store access, 0 for load |
| sup_mode | input | 1 | 1 when in supervisor mode |
| mmu_en | input | 1 | Translation enabled |
| mmu_present | input | 1 | Translation unit present |
| probe | input | 1 | Side-effect-free lookup |
| wr_en | input | 1 | Entry write strobe |
| wr_sel | input | 1 | 0 match word, 1 translate word |
| wr_way | input | WAY_W | Way to write |
| wr_set | input | SET_LOG2 | Set to write |
| wr_data | input | 32 | Word to write |
| rd_way | input | WAY_W | Way for match-word readback |
| rd_set | input | SET_LOG2 | Set for match-word readback |
| rd_match | output | 32 | Selected match word |
| rsp_valid | output | 1 | Result valid |
| paddr | output | 32 | Physical address |
| cache_inh | output | 1 | Cache inhibit |
| hit | output | 1 | Lookup hit |
| page_fault | output | 1 | Permission failure |
| tlb_miss | output | 1 | No matching entry |
| fault_addr | output | 32 | Address that faulted or missed |
| cfg_word | output | 32 | Geometry report |

## Verification
The embedded properties check on every cycle the following behaviours: pass-through in bypass mode, the one-cycle response timing, suppression of a lookup that collides with a write, the silence of probe lookups, that a miss always carries a zero address and that a fault is always a hit, and that stored words hold unless written or updated. The actual address arithmetic, the permission matrix across modes, the recency count values after a sequence of hits and probes, and the reset contents need known entries and expected values. Only the bench's scenarios can show those.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
    localparam int ADDR_W     = 32;
    localparam int M_VALID    = 0;
    localparam int USE_LSB    = 6;
    localparam int T_CI       = 1;
    localparam int T_SUP_RD   = 6;
    localparam int T_SUP_WR   = 7;
    localparam int T_USR_RD   = 8;
    localparam int T_USR_WR   = 9;

    typedef struct packed {
        logic              hit;
        logic              fault;
        logic              miss;
        logic              ci;
        logic [ADDR_W-1:0] paddr;
        logic [ADDR_W-1:0] faddr;
    } xlate_res_t;

    function automatic logic access_ok(input logic [ADDR_W-1:0] tw,
                                       input logic sup, input logic wr);
        logic need;
        if (sup) need = wr ? tw[T_SUP_WR] : tw[T_SUP_RD];
        else     need = wr ? tw[T_USR_WR] : tw[T_USR_RD];
        return need;
    endfunction
endpackage

// File: rtl/dtlb_array.sv
module dtlb_array
    import dtlb_pkg::*;
#(
    parameter int WAYS     = 2,
    parameter int SET_LOG2 = 6,
    parameter int USE_W    = 2,
    parameter int WAY_W    = 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic                          wr_sel,
    input  logic [WAY_W-1:0]              wr_way,
    input  logic [SET_LOG2-1:0]           wr_set,
    input  logic [ADDR_W-1:0]             wr_data,
    input  logic [SET_LOG2-1:0]           lk_set,
    input  logic                          upd_en,
    input  logic [WAY_W-1:0]              upd_way,
    input  logic [WAY_W-1:0]              rd_way,
    input  logic [SET_LOG2-1:0]           rd_set,
    output logic [WAYS-1:0][ADDR_W-1:0]   lk_match,
    output logic [WAYS-1:0][ADDR_W-1:0]   lk_trans,
    output logic [ADDR_W-1:0]             rd_match
);
    localparam int SETS   = 1 << SET_LOG2;
    localparam int SLOTS  = 1 << WAY_W;
    localparam logic [USE_W-1:0] RELOAD = USE_W'(SETS - 1);

    logic [SLOTS-1:0][ADDR_W-1:0] way_rd;

    function automatic logic [ADDR_W-1:0] age(input logic [ADDR_W-1:0] mw,
                                              input logic is_hit);
        logic [USE_W-1:0] cnt;
        logic [ADDR_W-1:0] res;
        cnt = mw[USE_LSB +: USE_W];
        if (cnt != '0) cnt = cnt - 1'b1;
        if (is_hit) cnt = cnt | RELOAD;
        res = mw;
        res[USE_LSB +: USE_W] = cnt;
        return res;
    endfunction

    for (genvar w = 0; w < SLOTS; w++) begin : g_way
        if (w < WAYS) begin : g_live
            logic [ADDR_W-1:0] m_q [SETS];
            logic [ADDR_W-1:0] t_q [SETS];
            logic              wsel;
            assign wsel = wr_en && (wr_way == WAY_W'(w));

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int s = 0; s < SETS; s++) begin
                        m_q[s] <= '0;
                        t_q[s] <= '0;
                    end
                end else if (wsel) begin
                    if (wr_sel) t_q[wr_set] <= wr_data;
                    else        m_q[wr_set] <= wr_data;
                end else if (upd_en) begin
                    m_q[lk_set] <= age(m_q[lk_set], upd_way == WAY_W'(w));
                end
            end

            assign lk_match[w] = m_q[lk_set];
            assign lk_trans[w] = t_q[lk_set];
            assign way_rd[w]   = m_q[rd_set];
        end else begin : g_pad
            assign way_rd[w] = '0;
        end
    end

    assign rd_match = way_rd[rd_way];

    AST_REC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !upd_en) ##1 ($stable(rd_way) && $stable(rd_set)) |-> $stable(rd_match)) // R7
        else $error("stored word changed without write or update");

    AST_WR_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel) ##1 (rd_way == $past(wr_way) && rd_set == $past(wr_set))
        |-> rd_match == $past(wr_data)) // R9
        else $error("match word write did not land");
endmodule

// File: rtl/dtlb_match.sv
module dtlb_match
    import dtlb_pkg::*;
#(
    parameter int WAYS      = 2,
    parameter int SET_LOG2  = 6,
    parameter int PAGE_LOG2 = 13,
    parameter int WAY_W     = 1
) (
    input  logic [ADDR_W-1:0]           vaddr,
    input  logic                        sup,
    input  logic                        wr,
    input  logic [WAYS-1:0][ADDR_W-1:0] match_w,
    input  logic [WAYS-1:0][ADDR_W-1:0] trans_w,
    output logic                        found,
    output logic [WAY_W-1:0]            found_way,
    output logic                        allowed,
    output logic                        ci,
    output logic [ADDR_W-1:0]           xaddr
);
    localparam int TAG_LSB = PAGE_LOG2 + SET_LOG2;

    logic [WAYS-1:0] way_hit;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w] = match_w[w][M_VALID] &&
                            (match_w[w][ADDR_W-1:TAG_LSB] == vaddr[ADDR_W-1:TAG_LSB]);
    end

    always_comb begin
        found_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_hit[w]) found_way = WAY_W'(w);
        end
    end

    logic [ADDR_W-1:0] tw;
    assign tw      = trans_w[found_way];
    assign found   = |way_hit;
    assign allowed = access_ok(tw, sup, wr);
    assign ci      = tw[T_CI];
    assign xaddr   = {tw[ADDR_W-1:PAGE_LOG2], vaddr[PAGE_LOG2-1:0]};
endmodule

// File: rtl/dtlb_xlate.sv
module dtlb_xlate
    import dtlb_pkg::*;
#(
    parameter int WAYS      = 2,
    parameter int SET_LOG2  = 6,
    parameter int PAGE_LOG2 = 13,
    parameter int USE_W     = 2,
    parameter int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    vaddr,
    input  logic                 is_write,
    input  logic                 sup_mode,
    input  logic                 mmu_en,
    input  logic                 mmu_present,
    input  logic                 probe,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [WAY_W-1:0]     wr_way,
    input  logic [SET_LOG2-1:0]  wr_set,
    input  logic [ADDR_W-1:0]    wr_data,
    input  logic [WAY_W-1:0]     rd_way,
    input  logic [SET_LOG2-1:0]  rd_set,
    output logic [ADDR_W-1:0]    rd_match,
    output logic                 rsp_valid,
    output logic [ADDR_W-1:0]    paddr,
    output logic                 cache_inh,
    output logic                 hit,
    output logic                 page_fault,
    output logic                 tlb_miss,
    output logic [ADDR_W-1:0]    fault_addr,
    output logic [ADDR_W-1:0]    cfg_word
);
    localparam logic [1:0] WAYS_FIELD = 2'(WAYS - 1);
    localparam logic [3:0] SETS_FIELD = 4'(SET_LOG2);

    logic [SET_LOG2-1:0]         set_idx;
    logic [WAYS-1:0][ADDR_W-1:0] m_words, t_words;
    logic                        found, allowed, ent_ci;
    logic [WAY_W-1:0]            found_way;
    logic [ADDR_W-1:0]           xaddr;
    logic                        accept, bypass, upd_en;
    xlate_res_t                  nxt, res_q;
    logic                        vld_q;

    assign set_idx = vaddr[PAGE_LOG2 +: SET_LOG2];
    assign accept  = req_valid && !wr_en;
    assign bypass  = !(mmu_en && mmu_present);
    assign upd_en  = accept && !bypass && !probe && found;

    dtlb_array #(.WAYS(WAYS), .SET_LOG2(SET_LOG2), .USE_W(USE_W), .WAY_W(WAY_W)) u_arr (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_way(wr_way), .wr_set(wr_set), .wr_data(wr_data),
        .lk_set(set_idx), .upd_en(upd_en), .upd_way(found_way),
        .rd_way(rd_way), .rd_set(rd_set),
        .lk_match(m_words), .lk_trans(t_words), .rd_match(rd_match)
    );

    dtlb_match #(.WAYS(WAYS), .SET_LOG2(SET_LOG2), .PAGE_LOG2(PAGE_LOG2), .WAY_W(WAY_W)) u_cmp (
        .vaddr(vaddr), .sup(sup_mode), .wr(is_write),
        .match_w(m_words), .trans_w(t_words),
        .found(found), .found_way(found_way), .allowed(allowed),
        .ci(ent_ci), .xaddr(xaddr)
    );

    always_comb begin
        nxt = '0;
        if (bypass) begin
            nxt.paddr = vaddr;
            nxt.ci    = vaddr[ADDR_W-1];
        end else if (!found) begin
            if (!probe) begin
                nxt.miss  = 1'b1;
                nxt.faddr = vaddr;
            end
        end else if (allowed) begin
            nxt.hit   = 1'b1;
            nxt.paddr = xaddr;
            nxt.ci    = ent_ci;
        end else if (!probe) begin
            nxt.hit   = 1'b1;
            nxt.fault = 1'b1;
            nxt.paddr = xaddr;
            nxt.ci    = ent_ci;
            nxt.faddr = vaddr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= accept;
            if (accept) res_q <= nxt;
        end
    end

    assign rsp_valid  = vld_q;
    assign paddr      = res_q.paddr;
    assign cache_inh  = res_q.ci;
    assign hit        = res_q.hit;
    assign page_fault = res_q.fault;
    assign tlb_miss   = res_q.miss;
    assign fault_addr = res_q.faddr;
    assign cfg_word   = {25'd0, SETS_FIELD, 1'b0, WAYS_FIELD};

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !wr_en && !(mmu_en && mmu_present)) |=>
        (rsp_valid && paddr == $past(vaddr) && cache_inh == $past(vaddr[ADDR_W-1]) &&
         !hit && !tlb_miss && !page_fault)) // R1
        else $error("bypass result wrong");

    AST_RSP_TIMING: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !wr_en) |=> rsp_valid) // R8
        else $error("missing response");

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (!req_valid || wr_en) |=> !rsp_valid) // R9
        else $error("response without accepted request");

    AST_PROBE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !wr_en && probe) |=> (!page_fault && !tlb_miss)) // R7
        else $error("probe raised an exception flag");

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        tlb_miss |-> (paddr == '0 && !hit && !page_fault)) // R5
        else $error("miss with nonzero address");

    AST_FAULT_HIT: assert property (@(posedge clk) disable iff (rst)
        page_fault |-> (hit && !tlb_miss)) // R4
        else $error("fault without hit");
endmodule

// File: tb/tb_dtlb_xlate.sv
module tb_dtlb_xlate;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, is_write, sup_mode, mmu_en, mmu_present, probe;
    logic [31:0] vaddr;
    logic        wr_en, wr_sel;
    logic [0:0]  wr_way, rd_way;
    logic [5:0]  wr_set, rd_set;
    logic [31:0] wr_data, rd_match;
    logic        rsp_valid, cache_inh, hit, page_fault, tlb_miss;
    logic [31:0] paddr, fault_addr, cfg_word;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dtlb_xlate dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .vaddr(vaddr), .is_write(is_write),
        .sup_mode(sup_mode), .mmu_en(mmu_en), .mmu_present(mmu_present), .probe(probe),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_way(wr_way), .wr_set(wr_set), .wr_data(wr_data),
        .rd_way(rd_way), .rd_set(rd_set), .rd_match(rd_match),
        .rsp_valid(rsp_valid), .paddr(paddr), .cache_inh(cache_inh), .hit(hit),
        .page_fault(page_fault), .tlb_miss(tlb_miss), .fault_addr(fault_addr),
        .cfg_word(cfg_word)
    );

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic        sup;
        logic        prb;
        logic [31:0] pa;
        logic        h;
        logic        pf;
        logic        ms;
        logic        ci;
        logic [3:0]  req;
    } vec_t;

    // Entries: set 5 way 0 tag 1 (supervisor rd/wr, user rd, ci); set 5 way 1 tag 2 (all perms);
    // set 7 way 0 tag 1 with valid bit 0.
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'h0008_A123, 1'b0, 1'b0, 1'b0, 32'h1234_6123, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3},  // R3
        '{32'h0008_A456, 1'b1, 1'b1, 1'b0, 32'h1234_6456, 1'b1, 1'b0, 1'b0, 1'b1, 4'd4},  // R4
        '{32'h0008_A010, 1'b1, 1'b0, 1'b0, 32'h1234_6010, 1'b1, 1'b1, 1'b0, 1'b1, 4'd4},  // R4
        '{32'h0010_BFFC, 1'b0, 1'b0, 1'b0, 32'h5555_1FFC, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
        '{32'h0018_A000, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5},  // R5
        '{32'h0008_C000, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 4'd2},  // R2
        '{32'h0008_E000, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 4'd2},  // R2 valid bit
        '{32'h0008_A010, 1'b1, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        '{32'h0018_A000, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        '{32'h0010_A004, 1'b0, 1'b0, 1'b1, 32'h5555_0004, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7}   // R7
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_word(input logic sel, input logic way, input logic [5:0] s,
                           input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_way = way; wr_set = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] va, input logic wr, input logic sup,
                          input logic prb, input logic en, input logic pres);
        @(negedge clk);
        req_valid = 1'b1; vaddr = va; is_write = wr; sup_mode = sup; probe = prb;
        mmu_en = en; mmu_present = pres;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 0; vaddr = 0; is_write = 0; sup_mode = 0; mmu_en = 1;
        mmu_present = 1; probe = 0; wr_en = 0; wr_sel = 0; wr_way = 0; wr_set = 0;
        wr_data = 0; rd_way = 0; rd_set = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        chk("R11 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R11 outputs", {28'd0, hit, page_fault, tlb_miss, cache_inh}, 32'd0);
        chk("R11 paddr", paddr, 32'd0);
        // R10 geometry word: ways-1 = 1, log2 sets = 6 at bit 3
        chk("R10 cfg_word", cfg_word, 32'h0000_0031);
        // R11 entries invalid after reset
        lookup(32'h0008_A000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        chk("R11 empty table miss", {31'd0, tlb_miss}, 32'd1);

        wr_word(1'b0, 1'b0, 6'd5, 32'h0008_0001);
        wr_word(1'b1, 1'b0, 6'd5, 32'h1234_61C2);
        wr_word(1'b0, 1'b1, 6'd5, 32'h0010_0001);
        wr_word(1'b1, 1'b1, 6'd5, 32'h5555_03C0);
        wr_word(1'b0, 1'b0, 6'd7, 32'h0008_0000);
        wr_word(1'b1, 1'b0, 6'd7, 32'h7777_03C0);
        rd_way = 1'b1; rd_set = 6'd5;
        #1;
        chk("R9 match readback", rd_match, 32'h0010_0001);

        for (int i = 0; i < NV; i++) begin
            lookup(VECS[i].va, VECS[i].wr, VECS[i].sup, VECS[i].prb, 1'b1, 1'b1);
            chk($sformatf("R%0d vec%0d flags", VECS[i].req, i),
                {27'd0, rsp_valid, hit, page_fault, tlb_miss, cache_inh},
                {27'd0, 1'b1, VECS[i].h, VECS[i].pf, VECS[i].ms, VECS[i].ci});
            chk($sformatf("R%0d vec%0d paddr", VECS[i].req, i), paddr, VECS[i].pa);
            chk($sformatf("R%0d vec%0d fault_addr", VECS[i].req, i), fault_addr,
                (VECS[i].pf || VECS[i].ms) ? VECS[i].va : 32'd0);
        end

        // R1 bypass cases
        lookup(32'h8000_0010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R1 bypass high", {paddr[31:1], cache_inh}, {31'h4000_0008, 1'b1});
        lookup(32'h7FFF_FFF0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R1 bypass low", {paddr[31:1], cache_inh}, {31'h3FFF_FFF8, 1'b0});
        lookup(32'h0018_A000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R1 absent unit", {paddr, 29'd0, hit, tlb_miss, page_fault}, {32'h0018_A000, 32'd0});

        // R6 recency: set 9, way 0 counter 0, way 1 counter 2 (bits 7:6)
        wr_word(1'b0, 1'b0, 6'd9, 32'h0008_0001);
        wr_word(1'b1, 1'b0, 6'd9, 32'h0000_03C0);
        wr_word(1'b0, 1'b1, 6'd9, 32'h0010_0081);
        wr_word(1'b1, 1'b1, 6'd9, 32'h0000_03C0);
        lookup(32'h0009_2000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        rd_set = 6'd9; rd_way = 1'b0; #1;
        chk("R6 hit way reload", rd_match, 32'h0008_00C1);
        rd_way = 1'b1; #1;
        chk("R6 other way decrement", rd_match, 32'h0010_0041);
        // R7 probe leaves counters
        lookup(32'h0011_2000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        chk("R7 probe hit", {31'd0, hit}, 32'd1);
        rd_way = 1'b0; #1;
        chk("R7 probe no update", rd_match, 32'h0008_00C1);
        lookup(32'h0011_2000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R6 second hit way0", rd_match, 32'h0008_0081);
        rd_way = 1'b1; #1;
        chk("R6 second hit way1", rd_match, 32'h0010_00C1);

        // R9 write collides with request: no response, no recency update
        @(negedge clk);
        req_valid = 1'b1; vaddr = 32'h0009_2000; probe = 1'b0;
        wr_en = 1'b1; wr_sel = 1'b1; wr_way = 1'b0; wr_set = 6'd20; wr_data = 32'h0;
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        chk("R9 no response on write", {31'd0, rsp_valid}, 32'd0);
        rd_way = 1'b0; #1;
        chk("R9 lookup dropped", rd_match, 32'h0008_0081);

        // R8 response lasts one cycle
        lookup(32'h0009_2000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        chk("R8 response present", {31'd0, rsp_valid}, 32'd1);
        @(negedge clk);
        chk("R8 response one cycle", {31'd0, rsp_valid}, 32'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule